// File: doc/BRIEF.md
# I2C Single-Byte Command Master

This block drives a two-wire serial bus as its only master and runs one complete transaction for each command it accepts. A command is either a read from a 7-bit target address or a write of one data byte to a 7-bit target address. The block sends a start condition and the address byte with the direction bit. For a write it then sends the data byte. For a read it clocks in one byte and answers it with a not-acknowledge. It always closes with a stop condition and then posts exactly one result record.

A result record has a success flag and a data byte. A successful read returns the received byte. A successful write returns zero. When the target does not acknowledge, the flag is clear and the data is zero. Commands use a valid/ready handshake. Results are a one-cycle valid pulse. Both bus lines are open drain: a drive output of 1 releases the line and 0 pulls it low. The SDA line level is read back through a synchronizer.

All bus timing comes from a `tick` enable that pulses at twice the bus bit rate, so each bit takes one SCL-low phase and one SCL-high phase. Tick pulses must be at least two clock cycles apart.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, and at any time the block is idle, `scl_o` = 1, `sda_o` = 1, `cmd_ready` = 1 and `res_valid` = 0. Asserting reset in the middle of a transaction returns the block to this state.
- R2: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `cmd_ready` stays 0 until the result is posted. Command inputs presented while busy are ignored and start no transaction.
- R3: Each transaction begins with exactly one start condition (SDA falls while SCL is high). It ends with exactly one stop condition (SDA rises while SCL is high), and the stop comes before `res_valid`.
- R4: `sda_o` never changes in the same cycle as `scl_o`. Apart from the start and stop conditions, SDA changes only while SCL is low.
- R5: `scl_o` changes only in the cycle after a `tick` pulse. Every SCL low phase and every SCL high phase in a transaction lasts exactly one tick interval. While `tick` is held low, `scl_o` and `sda_o` hold their values.
- R6: The first byte holds the 7 address bits MSB first, then a direction bit (1 = read, 0 = write). On the ninth clock the master releases SDA, and a low level sampled there is an acknowledge.
- R7: For a write whose address is acknowledged, the data byte is sent MSB first, followed by an acknowledge clock. If both bytes are acknowledged, the result is `res_ok` = 1 and `res_data` = 0x00.
- R8: For a read whose address is acknowledged, the master releases SDA for 8 clocks. It shifts in the line level sampled during each SCL-high phase, MSB first. It keeps SDA released on the ninth clock (not-acknowledge). The result is `res_ok` = 1 and `res_data` = the received byte.
- R9: If the address is not acknowledged, no further byte is clocked and a stop follows at once, giving 10 SCL rising edges in all (19 for a full two-byte transaction). The result is `res_ok` = 0 and `res_data` = 0x00.
- R10: If a write data byte is not acknowledged, the result is `res_ok` = 0 and `res_data` = 0x00.
- R11: Each accepted command produces exactly one `res_valid` pulse, one cycle long. `cmd_ready` is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timing enable at twice the bus bit rate |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can accept a command (idle) |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W (7) | Target address |
| cmd_wdata | input | DATA_W (8) | Byte to write |
| res_valid | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | 1 = success, 0 = failure marker |
| res_data | output | DATA_W (8) | Received byte, or 0x00 |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_o | output | 1 | SCL drive, 1 = released, 0 = pull low |
| sda_o | output | 1 | SDA drive, 1 = released, 0 = pull low |

## Verification
The bench places a bus target model on the wired-AND SDA line. It goes after a missing acknowledge at each of the two positions. If a master dropped the address-phase check, it would clock a second byte and show 19 SCL edges where 10 are expected. If it ignored a data-byte not-acknowledge, it would report a write as successful. The bench checks read bytes with the extreme bit values 0x00, 0xFF and 0x81, which expose a swapped shift direction or an off-by-one bit count. It holds `cmd_valid` high with changed fields throughout a transaction; a master that re-accepted while busy would show a second start condition or a second result. It freezes `tick` mid-byte, where a master with a free-running phase would keep moving SCL. It also asserts reset during a read, where a master that failed to return to idle would not release both lines.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HOLD,
        ST_LOW,
        ST_HIGH,
        ST_STOP_LO,
        ST_STOP_HI
    } bm_state_e;

endpackage

// File: rtl/i2c_bm_shifter.sv
module i2c_bm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic         msb,
    output logic [W-1:0] data,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } shf_t;

    shf_t shf_q, shf_d;

    always_comb begin
        shf_d = shf_q;
        if (load) begin
            shf_d.sh  = load_val;
            shf_d.cnt = '0;
        end else if (shift) begin
            shf_d.sh  = {shf_q.sh[W-2:0], sin};
            shf_d.cnt = shf_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign msb  = shf_q.sh[W-1];
    assign data = shf_q.sh;
    assign last = (shf_q.cnt == CW'(W));

endmodule

// File: rtl/i2c_bm_seq.sv
module i2c_bm_seq
    import i2c_bm_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              sda_s,
    input  logic              sh_msb,
    input  logic [DATA_W-1:0] sh_data,
    input  logic              sh_last,
    output logic              sh_load,
    output logic [DATA_W-1:0] sh_val,
    output logic              sh_shift,
    output logic              scl_o,
    output logic              sda_o,
    output logic              res_valid,
    output logic              res_ok,
    output logic [DATA_W-1:0] res_data
);
    typedef struct packed {
        bm_state_e         st;
        logic              rd;
        logic [DATA_W-1:0] wdata;
        logic              second;
        logic              drive;
        logic              fail;
        logic              scl;
        logic              sda;
        logic              res_valid;
        logic              res_ok;
        logic [DATA_W-1:0] res_data;
    } seq_t;

    seq_t seq_q, seq_d;
    logic acked;

    always_comb begin
        seq_d           = seq_q;
        seq_d.res_valid = 1'b0;
        sh_load         = 1'b0;
        sh_val          = '0;
        sh_shift        = 1'b0;
        acked           = ~sda_s;
        cmd_ready       = (seq_q.st == ST_IDLE);

        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.scl = 1'b1;
                seq_d.sda = 1'b1;
                if (cmd_valid) begin
                    seq_d.st     = ST_START;
                    seq_d.rd     = cmd_rd;
                    seq_d.wdata  = cmd_wdata;
                    seq_d.second = 1'b0;
                    seq_d.drive  = 1'b1;
                    seq_d.fail   = 1'b0;
                    sh_load      = 1'b1;
                    sh_val       = DATA_W'({cmd_addr, cmd_rd});
                end
            end
            ST_START: begin
                if (tick) begin
                    seq_d.sda = 1'b0;
                    seq_d.st  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    seq_d.scl = 1'b0;
                    seq_d.st  = ST_LOW;
                end
            end
            ST_LOW: begin
                // data or release lands one cycle after SCL fell
                seq_d.sda = (seq_q.drive && !sh_last) ? sh_msb : 1'b1;
                if (tick) begin
                    seq_d.scl = 1'b1;
                    seq_d.st  = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    seq_d.scl = 1'b0;
                    seq_d.st  = ST_LOW;
                    if (!sh_last) begin
                        sh_shift = 1'b1;
                    end else if (!seq_q.second) begin
                        if (!acked) begin
                            seq_d.fail = 1'b1;
                            seq_d.st   = ST_STOP_LO;
                        end else begin
                            seq_d.second = 1'b1;
                            seq_d.drive  = ~seq_q.rd;
                            sh_load      = 1'b1;
                            sh_val       = seq_q.rd ? '0 : seq_q.wdata;
                        end
                    end else begin
                        if (!seq_q.rd && !acked) seq_d.fail = 1'b1;
                        seq_d.st = ST_STOP_LO;
                    end
                end
            end
            ST_STOP_LO: begin
                seq_d.sda = 1'b0;
                if (tick) begin
                    seq_d.scl = 1'b1;
                    seq_d.st  = ST_STOP_HI;
                end
            end
            ST_STOP_HI: begin
                if (tick) begin
                    seq_d.sda       = 1'b1;
                    seq_d.st        = ST_IDLE;
                    seq_d.res_valid = 1'b1;
                    seq_d.res_ok    = ~seq_q.fail;
                    seq_d.res_data  = (!seq_q.fail && seq_q.rd) ? sh_data : '0;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q     <= '0;
            seq_q.st  <= ST_IDLE;
            seq_q.scl <= 1'b1;
            seq_q.sda <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign scl_o     = seq_q.scl;
    assign sda_o     = seq_q.sda;
    assign res_valid = seq_q.res_valid;
    assign res_ok    = seq_q.res_ok;
    assign res_data  = seq_q.res_data;

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              res_valid,
    output logic              res_ok,
    output logic [DATA_W-1:0] res_data,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_o
);
    logic              sda_s;
    logic              sh_msb;
    logic [DATA_W-1:0] sh_data;
    logic              sh_last;
    logic              sh_load;
    logic [DATA_W-1:0] sh_val;
    logic              sh_shift;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign sda_s = sda_i;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q, sync_d;
            always_comb begin
                sync_d = {sync_q[SYNC_STAGES-1:0], sda_i} >> 0;
                sync_d = SYNC_STAGES'({sync_q, sda_i});
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= sync_d;
            end
            assign sda_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    i2c_bm_shifter #(.W(DATA_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .sin      (sda_s),
        .msb      (sh_msb),
        .data     (sh_data),
        .last     (sh_last)
    );

    i2c_bm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_rd    (cmd_rd),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .sda_s     (sda_s),
        .sh_msb    (sh_msb),
        .sh_data   (sh_data),
        .sh_last   (sh_last),
        .sh_load   (sh_load),
        .sh_val    (sh_val),
        .sh_shift  (sh_shift),
        .scl_o     (scl_o),
        .sda_o     (sda_o),
        .res_valid (res_valid),
        .res_ok    (res_ok),
        .res_data  (res_data)
    );

endmodule

// File: rtl/i2c_bm_checker.sv
module i2c_bm_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              res_valid,
    input logic              res_ok,
    input logic [DATA_W-1:0] res_data,
    input logic              scl_o,
    input logic              sda_o
);
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (scl_o && sda_o));

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r4_sda_scl_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_o != $past(sda_o)) |-> (scl_o == $past(scl_o)));

    a_r5_scl_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o != $past(scl_o)) |-> $past(tick));

    a_r9_fail_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ok) |-> (res_data == '0));

    a_r11_result_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (cmd_ready && scl_o && sda_o));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

endmodule

bind i2c_byte_master i2c_bm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .res_valid (res_valid),
    .res_ok    (res_ok),
    .res_data  (res_data),
    .scl_o     (scl_o),
    .sda_o     (sda_o)
);

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
    localparam int AW = 7;
    localparam int DW = 8;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          ack_a;
        logic          ack_d;
        logic [DW-1:0] rbyte;
        logic [3:0]    per;
        logic          exp_ok;
        logic [DW-1:0] exp_data;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'h50, 8'hA5, 1'b1, 1'b1, 8'h00, 4'd4, 1'b1, 8'h00},
        '{1'b1, 7'h50, 8'h00, 1'b1, 1'b1, 8'h3C, 4'd4, 1'b1, 8'h3C},
        '{1'b0, 7'h2A, 8'h77, 1'b0, 1'b1, 8'h00, 4'd2, 1'b0, 8'h00},
        '{1'b0, 7'h11, 8'h80, 1'b1, 1'b0, 8'h00, 4'd3, 1'b0, 8'h00},
        '{1'b1, 7'h7F, 8'h00, 1'b0, 1'b1, 8'hC3, 4'd2, 1'b0, 8'h00},
        '{1'b1, 7'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 4'd2, 1'b1, 8'hFF},
        '{1'b1, 7'h01, 8'h00, 1'b1, 1'b1, 8'h00, 4'd5, 1'b1, 8'h00},
        '{1'b0, 7'h7F, 8'h00, 1'b1, 1'b1, 8'h00, 4'd3, 1'b1, 8'h00},
        '{1'b1, 7'h55, 8'h00, 1'b1, 1'b1, 8'h81, 4'd3, 1'b1, 8'h81}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_rd = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready, res_valid, res_ok, scl_o, sda_o;
    logic [DW-1:0] res_data;
    logic          drv = 1'b1;
    logic          sda_line;

    assign sda_line = sda_o & drv;

    always #4 clk = ~clk;

    i2c_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rd(cmd_rd),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .res_valid(res_valid), .res_ok(res_ok), .res_data(res_data),
        .sda_i(sda_line), .scl_o(scl_o), .sda_o(sda_o)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // tick generator
    int period = 4;
    bit tick_en = 1'b1;
    int tcnt = 0;
    always @(negedge clk) begin
        if (tick_en) begin
            if (tcnt >= period - 1) begin tick = 1'b1; tcnt = 0; end
            else begin tick = 1'b0; tcnt++; end
        end else begin
            tick = 1'b0;
        end
    end

    // bus target model and monitor
    bit            t_ack_a, t_ack_d;
    logic [DW-1:0] t_rbyte;
    bit            prev_scl = 1'b1, prev_line = 1'b1, have_edge;
    int            bitn, byte_idx, rises, starts, stops, plen, phase_bad;
    logic [DW-1:0] rx_sh, addr_seen, wbyte_seen;
    logic          mack;

    always @(negedge clk) begin
        logic line;
        line = sda_o & drv;
        plen++;
        if (prev_scl && scl_o) begin
            if (prev_line && !line) begin starts++; bitn = 0; byte_idx = 0; end
            if (!prev_line && line) stops++;
        end
        if (!prev_scl && scl_o) begin
            rises++;
            if (bitn < 8) rx_sh = {rx_sh[DW-2:0], line};
            else if (bitn == 8 && byte_idx == 1) mack = line;
            bitn++;
        end
        if (prev_scl != scl_o) begin
            if (have_edge && plen != period) phase_bad++;
            have_edge = 1'b1;
            plen = 0;
        end
        if (prev_scl && !scl_o) begin
            if (bitn == 9) begin byte_idx++; bitn = 0; end
            drv = 1'b1;
            if (bitn == 8) begin
                if (byte_idx == 0) begin
                    addr_seen = rx_sh;
                    drv = t_ack_a ? 1'b0 : 1'b1;
                end else if (byte_idx == 1 && !addr_seen[0]) begin
                    wbyte_seen = rx_sh;
                    drv = t_ack_d ? 1'b0 : 1'b1;
                end
            end else if (byte_idx == 1 && addr_seen[0] && t_ack_a && bitn < 8) begin
                drv = t_rbyte[7-bitn];
            end
        end
        prev_scl  = scl_o;
        prev_line = sda_o & drv;
    end

    task automatic mon_clear();
        bitn = 0; byte_idx = 0; rises = 0; starts = 0; stops = 0;
        plen = 0; phase_bad = 0; have_edge = 1'b0;
        rx_sh = '0; addr_seen = '0; wbyte_seen = '0; mack = 1'b0; drv = 1'b1;
        prev_scl = scl_o; prev_line = sda_o;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic run_vec(input vec_t v, input bit hold);
        int    results, ready_bad, waitc;
        bit    stop_first;
        logic  got_ok;
        logic [DW-1:0] got_data;
        string rtag;
        @(posedge clk); #1;
        period  = int'(v.per);
        t_ack_a = v.ack_a; t_ack_d = v.ack_d; t_rbyte = v.rbyte;
        mon_clear();
        step();
        cmd_valid = 1'b1; cmd_rd = v.rd; cmd_addr = v.addr; cmd_wdata = v.wdata;
        step();
        if (hold) begin
            cmd_rd = ~v.rd; cmd_addr = ~v.addr; cmd_wdata = ~v.wdata;
        end else begin
            cmd_valid = 1'b0;
        end
        results = 0; ready_bad = 0; waitc = 0; stop_first = 1'b0;
        got_ok = 1'b0; got_data = '0;
        while (results == 0 && waitc < 3000) begin
            if (res_valid) begin
                results++;
                stop_first = (stops == 1);
                got_ok = res_ok; got_data = res_data;
                cmd_valid = 1'b0;
            end else begin
                if (cmd_ready) ready_bad++;
                step();
            end
            waitc++;
        end
        for (int i = 0; i < 4 * int'(v.per); i++) begin
            step();
            if (res_valid) results++;
        end
        rtag = !v.ack_a ? "R9" : (v.rd ? "R8" : (v.ack_d ? "R7" : "R10"));
        check(results == 1, "R11", "result pulses", results, 1);
        check(ready_bad == 0, "R2", "ready while busy", ready_bad, 0);
        check(got_ok == v.exp_ok, rtag, "res_ok", int'(got_ok), int'(v.exp_ok));
        check(got_data == v.exp_data, rtag, "res_data", int'(got_data), int'(v.exp_data));
        check(addr_seen == {v.addr, v.rd}, "R6", "address byte", int'(addr_seen), int'({v.addr, v.rd}));
        if (!v.rd && v.ack_a)
            check(wbyte_seen == v.wdata, "R7", "write byte", int'(wbyte_seen), int'(v.wdata));
        if (v.rd && v.ack_a)
            check(mack == 1'b1, "R8", "master nack", int'(mack), 1);
        check(rises == (v.ack_a ? 19 : 10), "R9", "SCL rises", rises, v.ack_a ? 19 : 10);
        check(starts == 1, "R3", "start count", starts, 1);
        check(stop_first, "R3", "stop before result", int'(stop_first), 1);
        check(phase_bad == 0, "R5", "phase length errors", phase_bad, 0);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R11 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic s_scl, s_sda;
        int moved;
        int waitc;
        // R1: reset state
        repeat (3) step();
        check(scl_o == 1'b1 && sda_o == 1'b1, "R1", "lines in reset", int'({scl_o, sda_o}), 3);
        rst_n = 1'b1;
        repeat (3) step();
        check(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
        check(res_valid == 1'b0, "R1", "no result after reset", int'(res_valid), 0);
        check(scl_o == 1'b1 && sda_o == 1'b1, "R1", "lines idle", int'({scl_o, sda_o}), 3);

        // table of vectors
        for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);

        // R2: command held valid with changed fields while busy
        run_vec(VECS[0], 1'b1);
        repeat (10) step();
        check(cmd_ready == 1'b1 && scl_o == 1'b1, "R2", "no second transaction", int'({cmd_ready, scl_o}), 3);
        check(starts == 1, "R2", "starts after busy hold", starts, 1);

        // R5: freeze tick mid transaction
        period = 3; t_ack_a = 1'b1; t_ack_d = 1'b1;
        mon_clear();
        cmd_valid = 1'b1; cmd_rd = 1'b0; cmd_addr = 7'h22; cmd_wdata = 8'h5E;
        step();
        cmd_valid = 1'b0;
        repeat (40) step();
        tick_en = 1'b0;
        repeat (2) step();
        s_scl = scl_o; s_sda = sda_o; moved = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (scl_o != s_scl || sda_o != s_sda) moved++;
        end
        check(moved == 0, "R5", "bus moved without tick", moved, 0);
        tick_en = 1'b1;
        waitc = 0;
        while (!res_valid && waitc < 3000) begin step(); waitc++; end
        check(res_valid && res_ok && res_data == 8'h00, "R7", "write after freeze",
              int'({res_valid, res_ok}), 3);

        // R1: reset in the middle of a read
        repeat (5) step();
        period = 4; t_ack_a = 1'b1; t_rbyte = 8'h00;
        mon_clear();
        cmd_valid = 1'b1; cmd_rd = 1'b1; cmd_addr = 7'h33;
        step();
        cmd_valid = 1'b0;
        repeat (50) step();
        rst_n = 1'b0;
        step();
        check(scl_o && sda_o && cmd_ready && !res_valid, "R1", "mid-transaction reset",
              int'({scl_o, sda_o, cmd_ready, res_valid}), 14);
        rst_n = 1'b1;
        repeat (5) step();
        run_vec(VECS[1], 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule